// File: doc/BRIEF.md
# Clearing Block RAM

A single-clock memory of `DEPTH` words of `WIDTH` bits. It has one synchronous read port and one write port. The contents at power-up are unknown. When the build option `CLEAR_ON_RESET` is set, reset starts a sweep that fills the whole array. The sweep runs one address per enabled cycle, from the lowest address to the highest. It loads either the constant `FILL_CONST` into every word, or the index of each word XORed with `FILL_KEY`. `busy` is high for the length of the sweep.

A global enable `en` gates every state change: the sweep, user writes and the read register. When `CLEAR_ON_RESET` is clear, reset leaves the array as it was. The block then accepts accesses on the first cycle after release. A read and a write to the same address in one cycle return the contents from before the write. The state machine has two states:

- **ST_SWEEP** writes the fill value at the sweep index and steps the index. Transition SWEEP_DONE leads to ST_READY after the last index.
- **ST_READY** serves user reads and writes.

Reset enters ST_SWEEP when clearing is enabled and ST_READY when it is not. `DEPTH` must be at least 1.

Top module: `sweep_ram`

## Requirements
- R1: With `en` high, `rd_data` shows the word at `rd_addr` from the clock edge after the address is presented.
- R2: With `en` high, `busy` low and `wr_valid` high, `wr_data` is stored at `wr_addr` on that edge.
- R3: When the same address is read and written in one cycle, `rd_data` returns the contents from before the write.
- R4: With `CLEAR_ON_RESET`=1, `busy` is high while reset is held. After release it stays high for exactly `DEPTH` enabled cycles, then stays low until the next reset.
- R5: The sweep writes word i on the i-th enabled cycle after release, in ascending order. A cycle with `en` low pauses the sweep without losing its place.
- R6: With `FILL_MODE`=FILL_CONST_ALL, every word holds `FILL_CONST` after the sweep.
- R7: With `FILL_MODE`=FILL_INDEX_XOR, word i holds i XOR `FILL_KEY` (i zero-extended to `WIDTH` bits) after the sweep.
- R8: While `busy` is high, user writes are ignored. The swept words hold the fill value afterwards.
- R9: With `CLEAR_ON_RESET`=0, reset leaves the contents intact and `busy` stays low.
- R10: With `en` low, nothing is written, `rd_data` holds its value and the sweep does not advance.
- R11: A write to an address at or above `DEPTH` is discarded. A read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable for sweep, writes and read register |
| rd_addr | input | AW | Read address |
| wr_valid | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data |
| busy | output | 1 | High while the clearing sweep runs |

## Verification
The bench builds three copies of the block, each with `DEPTH`=12 and `WIDTH`=8, all driven by the same stimulus:

- The first sweeps with the index-XOR fill using key 0x5A.
- The second sweeps with the constant 0xC3.
- The third has clearing disabled.

A depth that is not a power of two puts addresses 12 to 15 within reach of the 4-bit address ports, so the out-of-range rules are exercised. Sharing the stimulus allows the same writes to be issued while two copies are busy and one is not. A second reset then shows two arrays refilled next to one whose contents survive.

// File: rtl/sweep_ram_pkg.sv
package sweep_ram_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_READY = 1'b1
    } sweep_state_e;

    // Fill rule applied by the sweep
    typedef enum bit {
        FILL_CONST_ALL = 1'b0,
        FILL_INDEX_XOR = 1'b1
    } fill_mode_e;

endpackage

// File: rtl/sweep_ram_seq.sv
module sweep_ram_seq
    import sweep_ram_pkg::*;
#(
    parameter int DEPTH          = 64,
    parameter bit CLEAR_ON_RESET = 1'b1,
    localparam int AW            = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic          busy,
    output logic          sweep_we,
    output logic [AW-1:0] sweep_idx
);

    localparam logic [AW-1:0]  LAST_IDX  = AW'(DEPTH - 1);
    localparam sweep_state_e   RST_STATE = CLEAR_ON_RESET ? ST_SWEEP : ST_READY;

    sweep_state_e  state_q, state_d;
    logic [AW-1:0] idx_q, idx_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RST_STATE;
            idx_q   <= '0;
        end else if (en) begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state: SWEEP_DONE leaves ST_SWEEP after the last index
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_SWEEP: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_READY;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_READY: begin
                state_d = ST_READY;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q == ST_SWEEP);
        sweep_we  = (state_q == ST_SWEEP) && !rst;
        sweep_idx = idx_q;
    end

endmodule

// File: rtl/sweep_ram_fill.sv
module sweep_ram_fill
    import sweep_ram_pkg::*;
#(
    parameter int                DEPTH      = 64,
    parameter int                WIDTH      = 16,
    parameter fill_mode_e        FILL_MODE  = FILL_INDEX_XOR,
    parameter logic [WIDTH-1:0]  FILL_CONST = '0,
    parameter logic [WIDTH-1:0]  FILL_KEY   = '0,
    localparam int               AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0]    idx,
    output logic [WIDTH-1:0] value
);

    generate
        if (FILL_MODE == FILL_CONST_ALL) begin : g_const
            logic unused_idx;
            assign unused_idx = ^idx;
            assign value = FILL_CONST;
        end else begin : g_index
            assign value = WIDTH'(idx) ^ FILL_KEY;
        end
    endgenerate

endmodule

// File: rtl/sweep_ram_array.sv
module sweep_ram_array #(
    parameter int  DEPTH = 64,
    parameter int  WIDTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    localparam logic [AW:0] DEPTH_W = (AW + 1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic             rd_ok;

    assign rd_ok = ({1'b0, raddr} < DEPTH_W);

    // Read before write: the read register takes the old word
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[waddr] <= wdata;
            end
            rdata <= rd_ok ? mem[raddr] : '0;
        end
    end

endmodule

// File: rtl/sweep_ram.sv
module sweep_ram
    import sweep_ram_pkg::*;
#(
    parameter int                DEPTH          = 64,
    parameter int                WIDTH          = 16,
    parameter bit                CLEAR_ON_RESET = 1'b1,
    parameter fill_mode_e        FILL_MODE      = FILL_INDEX_XOR,
    parameter logic [WIDTH-1:0]  FILL_CONST     = '0,
    parameter logic [WIDTH-1:0]  FILL_KEY       = '0,
    localparam int               AW             = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy
);

    localparam logic [AW:0] DEPTH_W = (AW + 1)'(DEPTH);

    generate
        if (DEPTH < 1) begin : g_bad_depth
            $error("sweep_ram: DEPTH must be at least 1");
        end
    endgenerate

    logic             sweep_we;
    logic [AW-1:0]    sweep_idx;
    logic [WIDTH-1:0] fill_value;
    logic             user_we;
    logic             arr_we;
    logic [AW-1:0]    arr_waddr;
    logic [WIDTH-1:0] arr_wdata;

    sweep_ram_seq #(
        .DEPTH          (DEPTH),
        .CLEAR_ON_RESET (CLEAR_ON_RESET)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .busy      (busy),
        .sweep_we  (sweep_we),
        .sweep_idx (sweep_idx)
    );

    sweep_ram_fill #(
        .DEPTH      (DEPTH),
        .WIDTH      (WIDTH),
        .FILL_MODE  (FILL_MODE),
        .FILL_CONST (FILL_CONST),
        .FILL_KEY   (FILL_KEY)
    ) u_fill (
        .idx   (sweep_idx),
        .value (fill_value)
    );

    // User path is closed during reset, during the sweep and for out-of-range addresses
    assign user_we = wr_valid && !rst && ({1'b0, wr_addr} < DEPTH_W);

    always_comb begin
        if (busy) begin
            arr_we    = sweep_we;
            arr_waddr = sweep_idx;
            arr_wdata = fill_value;
        end else begin
            arr_we    = user_we;
            arr_waddr = wr_addr;
            arr_wdata = wr_data;
        end
    end

    sweep_ram_array #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_array (
        .clk   (clk),
        .en    (en),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/sweep_ram_chk.sv
module sweep_ram_chk #(
    parameter int DEPTH          = 64,
    parameter int AW             = 6,
    parameter bit CLEAR_ON_RESET = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          busy,
    input logic [AW-1:0] sweep_idx,
    input logic          arr_we,
    input logic [AW-1:0] arr_waddr
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [AW:0]   DEPTH_W  = (AW + 1)'(DEPTH);

    AST_SWEEP_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (busy == CLEAR_ON_RESET));                               // R4

    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && en && sweep_idx == LAST_IDX) |=> !busy);                       // R4

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);                                                       // R4

    AST_SWEEP_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && en && sweep_idx != LAST_IDX) |=>
            (busy && sweep_idx == AW'($past(sweep_idx) + 1'b1)));               // R5

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(busy) && $stable(sweep_idx)));                         // R10

    AST_SWEEP_OWNS_PORT: assert property (@(posedge clk) disable iff (rst)
        (busy && arr_we) |-> (arr_waddr == sweep_idx));                         // R8

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> ({1'b0, arr_waddr} < DEPTH_W));                              // R11

endmodule

bind sweep_ram sweep_ram_chk #(
    .DEPTH          (DEPTH),
    .AW             (AW),
    .CLEAR_ON_RESET (CLEAR_ON_RESET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .busy      (busy),
    .sweep_idx (sweep_idx),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr)
);

// File: tb/test_sweep_ram.sv
module test_sweep_ram;
    import sweep_ram_pkg::*;

    localparam int DEPTH = 12;
    localparam int W     = 8;
    localparam int AWB   = 4;
    localparam int KEY   = 'h5A;
    localparam int CONSTV = 'hC3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           en = 1'b1;
    logic [AWB-1:0] rd_addr = '0;
    logic           wr_valid = 1'b0;
    logic [AWB-1:0] wr_addr = '0;
    logic [W-1:0]   wr_data = '0;
    logic [2:0][W-1:0] rd_o;
    logic [2:0]        busy_o;

    always #4 clk = ~clk;  // 125 MHz

    sweep_ram #(.DEPTH(DEPTH), .WIDTH(W), .CLEAR_ON_RESET(1'b1),
                .FILL_MODE(FILL_INDEX_XOR), .FILL_CONST(8'h00), .FILL_KEY(8'h5A))
    i_sweep_ram (.clk(clk), .rst(rst), .en(en), .rd_addr(rd_addr), .wr_valid(wr_valid),
                 .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_o[0]), .busy(busy_o[0]));

    sweep_ram #(.DEPTH(DEPTH), .WIDTH(W), .CLEAR_ON_RESET(1'b1),
                .FILL_MODE(FILL_CONST_ALL), .FILL_CONST(8'hC3), .FILL_KEY(8'h00))
    i_sweep_ram_const (.clk(clk), .rst(rst), .en(en), .rd_addr(rd_addr), .wr_valid(wr_valid),
                 .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_o[1]), .busy(busy_o[1]));

    sweep_ram #(.DEPTH(DEPTH), .WIDTH(W), .CLEAR_ON_RESET(1'b0),
                .FILL_MODE(FILL_CONST_ALL), .FILL_CONST(8'h00), .FILL_KEY(8'h00))
    i_sweep_ram_keep (.clk(clk), .rst(rst), .en(en), .rd_addr(rd_addr), .wr_valid(wr_valid),
                 .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_o[2]), .busy(busy_o[2]));

    // Behavioural reference model
    int    mem  [3][16];
    bit    memv [3][16];
    bit    sweeping [3];
    int    idx  [3];
    int    exp_rd [3];
    bit    exp_rdv [3];
    bit    clr [3] = '{1'b1, 1'b1, 1'b0};
    bit    started = 1'b0;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string cur_req = "R4";

    function automatic int fill_of(input int k, input int i);
        if (k == 0) return (i ^ KEY) & 'hFF;
        return CONSTV;
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (rst) begin
                sweeping[k] = clr[k];
                idx[k]      = 0;
                exp_rdv[k]  = 1'b0;
            end else if (en) begin
                if (sweeping[k]) begin
                    mem[k][idx[k]]  = fill_of(k, idx[k]);
                    memv[k][idx[k]] = 1'b1;
                    exp_rdv[k]      = 1'b0;
                    if (idx[k] == DEPTH - 1) sweeping[k] = 1'b0;
                    else idx[k] = idx[k] + 1;
                end else begin
                    if (int'(rd_addr) >= DEPTH) begin
                        exp_rd[k]  = 0;
                        exp_rdv[k] = 1'b1;
                    end else begin
                        exp_rd[k]  = mem[k][rd_addr];
                        exp_rdv[k] = memv[k][rd_addr];
                    end
                    if (wr_valid && int'(wr_addr) < DEPTH) begin
                        mem[k][wr_addr]  = int'(wr_data);
                        memv[k][wr_addr] = 1'b1;
                    end
                end
            end
        end
        started = 1'b1;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog %s: got %0d cycles expected completion", cur_req, cycles);
            finish_run();
        end
        if (started) begin
            for (int k = 0; k < 3; k++) begin
                checks++;
                if (busy_o[k] !== sweeping[k]) begin
                    fails++;
                    $display("FAIL %s inst%0d busy: got %0b expected %0b",
                             cur_req, k, busy_o[k], sweeping[k]);
                end
                if (exp_rdv[k]) begin
                    checks++;
                    if (int'(rd_o[k]) !== exp_rd[k]) begin
                        fails++;
                        $display("FAIL %s inst%0d rd_data: got %h expected %h",
                                 cur_req, k, rd_o[k], exp_rd[k][7:0]);
                    end
                end
            end
        end
    end

    task automatic cyc(input bit e, input int ra, input bit wv, input int wa, input int wd);
        @(negedge clk);
        en       = e;
        rd_addr  = AWB'(ra);
        wr_valid = wv;
        wr_addr  = AWB'(wa);
        wr_data  = W'(wd);
    endtask

    initial begin
        // R4 / R9: state during reset
        cur_req = "R4";
        repeat (3) cyc(1'b1, 0, 1'b0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        // R8: writes during the sweep are ignored by the clearing copies
        cur_req = "R8";
        for (int i = 0; i < 4; i++) cyc(1'b1, i, 1'b1, 3, 'h11 + i);
        // R5 / R10: sweep pauses while en is low
        cur_req = "R5";
        for (int i = 0; i < 3; i++) cyc(1'b0, 7, 1'b1, 6, 'h66);
        cur_req = "R8";
        for (int i = 0; i < 8; i++) cyc(1'b1, i, 1'b1, 5, 'h22 + i);
        // R6/R7: swept contents
        cur_req = "R6/R7";
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, i, 1'b0, 0, 0);
        // R2: writes with mixed reads
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, (i + 5) % DEPTH, 1'b1, i, i * 7 + 1);
        // R1: read back
        cur_req = "R1";
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, DEPTH - 1 - i, 1'b0, 0, 0);
        // R3: same-address read and write
        cur_req = "R3";
        cyc(1'b1, 2, 1'b1, 2, 'hAA);
        cyc(1'b1, 2, 1'b0, 0, 0);
        cyc(1'b1, 2, 1'b1, 2, 'hBB);
        cyc(1'b1, 2, 1'b0, 0, 0);
        // R10: disabled cycles change nothing
        cur_req = "R10";
        cyc(1'b0, 9, 1'b1, 4, 'h77);
        cyc(1'b0, 9, 1'b1, 4, 'h78);
        cyc(1'b1, 4, 1'b0, 0, 0);
        cyc(1'b1, 9, 1'b0, 0, 0);
        // R11: out-of-range addresses
        cur_req = "R11";
        cyc(1'b1, 14, 1'b1, 13, 'h55);
        cyc(1'b1, 13, 1'b1, 15, 'h56);
        cyc(1'b1, 1, 1'b0, 0, 0);
        // R9: second reset keeps the non-clearing copy, refills the others
        cur_req = "R9";
        cyc(1'b1, 0, 1'b0, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        cyc(1'b1, 0, 1'b0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, i, 1'b0, 0, 0);
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, i, 1'b0, 0, 0);
        cyc(1'b1, 0, 1'b0, 0, 0);
        cyc(1'b1, 0, 1'b0, 0, 0);
        @(negedge clk);
        finish_run();
    end

endmodule